// File: doc/BRIEF.md
# Pipeline Hazard and Stall Controller

This block decides, cycle by cycle, whether the instruction waiting in the decode stage of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) may issue. It also tells the execute-stage operand multiplexers where each operand should come from. The pipeline has two execute paths. Integer, load and store instructions spend a single cycle in execute. Floating-point adds pass through a pipelined adder with `FP_STAGES` stages, called A0 to A3 at the default of four, and only then reach the memory stage. All register tags share one namespace.

Each cycle the block receives the class and the register tags of the decode-stage instruction. It keeps its own record of which instruction occupies the issue slot (execute or A0), each later adder stage, memory and writeback. From that record and the decode inputs it produces four things: a freeze for the program counter and the fetch/decode register, a bubble for the issue slot, a hold for the issue slot when the single memory port is contested, and three forward selects (operand A, operand B, store data) for the instruction in the issue slot. Instructions already past a stalled stage always keep moving, so whatever is being waited on completes.

Top module: `hzc_ctrl`

## Requirements
- R1: Class codes on `id_cls` are 0 integer ALU, 1 load, 2 store, 3 FP add, 4 FP store. Every class reads `id_src_a`. ALU, store, FP add and FP store also read `id_src_b`, and for the two store classes it is the store-data register. ALU, load and FP add write `id_dst`. A load's `id_src_b` never causes a stall.
- R2: While reset is asserted and right after it, the record is empty: `front_hold`, `issue_bubble`, `issue_hold` and `mem_from_fp` are 0 and all forward selects are 00.
- R3: When the issue slot holds a load and the decode instruction reads the load's nonzero destination, `front_hold` and `issue_bubble` are 1 for exactly one cycle. In the cycle after the dependent instruction issues, its select is 01.
- R4: A store whose data register is written by the ALU instruction directly ahead of it issues without a stall. In the next cycle `fwd_sd` is 10.
- R5: An FP add in the issue slot, or in any adder stage except the last, blocks a decode instruction that reads or writes its nonzero destination (`front_hold`=1, `issue_bubble`=1). A dependent store behind an FP add therefore waits three cycles at the default depth and then sees `fwd_sd`=10.
- R6: When the issue slot holds a non-FP instruction and the last adder stage is occupied, the FP add takes the memory port. `issue_hold`, `front_hold` and `mem_from_fp` are 1, `issue_bubble` is 0, and the held instruction enters memory one cycle later.
- R7: Forward selects encode 00 register file, 01 memory/writeback result, 10 execute/memory result; 11 never occurs. The execute/memory source is an ALU or FP add result in the memory stage. The memory/writeback source is an ALU, load or FP add in writeback. The memory-stage source wins when both match.
- R8: `fwd_a` serves the issue-slot instruction's first source. `fwd_b` serves its second source only for ALU and FP add. `fwd_sd` serves the second source only for the two store classes. Every select is 00 when the slot is empty.
- R9: Tag 0 is never forwarded (select 00) and never causes a stall.
- R10: `mem_from_fp` is 1 exactly when the last adder stage is occupied. That instruction enters memory on the next edge whatever the stall state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_valid | input | 1 | Decode stage holds an instruction |
| id_cls | input | 3 | Decode instruction class (R1 codes) |
| id_src_a | input | TAG_W | First source tag |
| id_src_b | input | TAG_W | Second source / store-data tag |
| id_dst | input | TAG_W | Destination tag |
| front_hold | output | 1 | Freeze program counter and fetch/decode register |
| issue_bubble | output | 1 | Load an empty slot into the issue stage |
| issue_hold | output | 1 | Issue slot keeps its instruction (memory port lost) |
| mem_from_fp | output | 1 | Adder result owns the memory port this cycle |
| fwd_a | output | 2 | Forward select, first operand |
| fwd_b | output | 2 | Forward select, second operand |
| fwd_sd | output | 2 | Forward select, store data |

## Verification
The assertions take for granted that the decode inputs stay stable while `front_hold` is high, and that `id_cls` carries only the five defined codes. The bench honours both. It re-presents the same instruction every cycle until its own model says the instruction was accepted, and it draws classes only from the defined set. Tags are drawn mostly from 0 to 3, so load-use, adder RAW/WAW, tag-0 and memory-port conflicts occur often. Directed sequences then pin down the exact stall counts and select values.

// File: rtl/hzc_pkg.sv
package hzc_pkg;

   typedef enum logic [2:0] {
      CL_ALU   = 3'd0,
      CL_LOAD  = 3'd1,
      CL_STORE = 3'd2,
      CL_FPADD = 3'd3,
      CL_FPST  = 3'd4
   } icls_e;

   localparam logic [1:0] FWD_RF  = 2'b00;
   localparam logic [1:0] FWD_WB  = 2'b01;
   localparam logic [1:0] FWD_MEM = 2'b10;

   // class writes a destination register
   function automatic logic cls_writes(input logic [2:0] c);
      return (c == CL_ALU) || (c == CL_LOAD) || (c == CL_FPADD);
   endfunction

   // class reads its second source tag
   function automatic logic cls_reads_b(input logic [2:0] c);
      return (c == CL_ALU) || (c == CL_STORE) || (c == CL_FPADD) || (c == CL_FPST);
   endfunction

   // second source feeds the execute unit
   function automatic logic cls_exec_b(input logic [2:0] c);
      return (c == CL_ALU) || (c == CL_FPADD);
   endfunction

   // second source is store data
   function automatic logic cls_stores(input logic [2:0] c);
      return (c == CL_STORE) || (c == CL_FPST);
   endfunction

   // result already present in the memory-stage register
   function automatic logic cls_early(input logic [2:0] c);
      return (c == CL_ALU) || (c == CL_FPADD);
   endfunction

endpackage

// File: rtl/hzc_track.sv
module hzc_track
   import hzc_pkg::*;
#(
   parameter int TAG_W     = 5,
   parameter int FP_STAGES = 4
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              issue_en,
   input  logic [2:0]                        id_cls,
   input  logic [TAG_W-1:0]                  id_src_a,
   input  logic [TAG_W-1:0]                  id_src_b,
   input  logic [TAG_W-1:0]                  id_dst,
   output logic                              x_valid,
   output logic [2:0]                        x_cls,
   output logic [TAG_W-1:0]                  x_src_a,
   output logic [TAG_W-1:0]                  x_src_b,
   output logic [TAG_W-1:0]                  x_dst,
   output logic [FP_STAGES-1:1]              fp_valid,
   output logic [FP_STAGES-1:1][TAG_W-1:0]   fp_dst,
   output logic                              m_valid,
   output logic [2:0]                        m_cls,
   output logic [TAG_W-1:0]                  m_dst,
   output logic                              w_valid,
   output logic [2:0]                        w_cls,
   output logic [TAG_W-1:0]                  w_dst,
   output logic                              mem_clash,
   output logic                              mem_from_fp
);

   localparam int LAST = FP_STAGES - 1;

   logic x_is_fp;

   assign x_is_fp     = x_valid && (x_cls == CL_FPADD);
   assign mem_from_fp = fp_valid[LAST];
   assign mem_clash   = x_valid && !x_is_fp && fp_valid[LAST];

   // issue slot (execute for integer classes, A0 for the adder)
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         x_valid <= 1'b0;
         x_cls   <= CL_ALU;
         x_src_a <= '0;
         x_src_b <= '0;
         x_dst   <= '0;
      end else if (!mem_clash) begin
         x_valid <= issue_en;
         if (issue_en) begin
            x_cls   <= id_cls;
            x_src_a <= id_src_a;
            x_src_b <= id_src_b;
            x_dst   <= id_dst;
         end
      end
   end

   // adder stage A1 is fed by the issue slot
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fp_valid[1] <= 1'b0;
         fp_dst[1]   <= '0;
      end else begin
         fp_valid[1] <= x_is_fp;
         fp_dst[1]   <= x_dst;
      end
   end

   // remaining adder stages shift unconditionally
   for (genvar k = 2; k <= LAST; k++) begin : g_fp_stage
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            fp_valid[k] <= 1'b0;
            fp_dst[k]   <= '0;
         end else begin
            fp_valid[k] <= fp_valid[k-1];
            fp_dst[k]   <= fp_dst[k-1];
         end
      end
   end

   // single memory port: the adder output has precedence
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         m_valid <= 1'b0;
         m_cls   <= CL_ALU;
         m_dst   <= '0;
      end else if (fp_valid[LAST]) begin
         m_valid <= 1'b1;
         m_cls   <= CL_FPADD;
         m_dst   <= fp_dst[LAST];
      end else if (x_valid && !x_is_fp) begin
         m_valid <= 1'b1;
         m_cls   <= x_cls;
         m_dst   <= x_dst;
      end else begin
         m_valid <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         w_valid <= 1'b0;
         w_cls   <= CL_ALU;
         w_dst   <= '0;
      end else begin
         w_valid <= m_valid;
         w_cls   <= m_cls;
         w_dst   <= m_dst;
      end
   end

endmodule

// File: rtl/hzc_detect.sv
module hzc_detect
   import hzc_pkg::*;
#(
   parameter int TAG_W       = 5,
   parameter int FP_STAGES   = 4,
   parameter int ZERO_TAG_EN = 1
) (
   input  logic                              id_valid,
   input  logic [2:0]                        id_cls,
   input  logic [TAG_W-1:0]                  id_src_a,
   input  logic [TAG_W-1:0]                  id_src_b,
   input  logic [TAG_W-1:0]                  id_dst,
   input  logic                              x_valid,
   input  logic [2:0]                        x_cls,
   input  logic [TAG_W-1:0]                  x_dst,
   input  logic [FP_STAGES-1:1]              fp_valid,
   input  logic [FP_STAGES-1:1][TAG_W-1:0]   fp_dst,
   input  logic                              mem_clash,
   output logic                              front_hold,
   output logic                              issue_bubble
);

   // adder results not yet forwardable: issue slot plus A1..A(n-2)
   localparam int NPEND = FP_STAGES - 1;

   function automatic logic tag_live(input logic [TAG_W-1:0] t);
      return (ZERO_TAG_EN == 0) || (t != '0);
   endfunction

   logic                          rd_b, wr_d;
   logic                          load_use, fp_wait, hazard;
   logic [NPEND-1:0]              pend_v, pend_hit;
   logic [NPEND-1:0][TAG_W-1:0]   pend_d;

   assign rd_b = cls_reads_b(id_cls);
   assign wr_d = cls_writes(id_cls);

   assign pend_v[0] = x_valid && (x_cls == CL_FPADD);
   assign pend_d[0] = x_dst;

   for (genvar k = 1; k < NPEND; k++) begin : g_pend
      assign pend_v[k] = fp_valid[k];
      assign pend_d[k] = fp_dst[k];
   end

   for (genvar k = 0; k < NPEND; k++) begin : g_hit
      assign pend_hit[k] = pend_v[k] && tag_live(pend_d[k]) &&
                           ((id_src_a == pend_d[k]) ||
                            (rd_b && (id_src_b == pend_d[k])) ||
                            (wr_d && (id_dst == pend_d[k])));
   end

   assign load_use = x_valid && (x_cls == CL_LOAD) && tag_live(x_dst) &&
                     ((id_src_a == x_dst) || (rd_b && (id_src_b == x_dst)));
   assign fp_wait  = |pend_hit;
   assign hazard   = id_valid && (load_use || fp_wait);

   assign front_hold   = hazard || mem_clash;
   assign issue_bubble = hazard && !mem_clash;

endmodule

// File: rtl/hzc_fwd_sel.sv
module hzc_fwd_sel
   import hzc_pkg::*;
#(
   parameter int TAG_W       = 5,
   parameter int ZERO_TAG_EN = 1
) (
   input  logic              need,
   input  logic [TAG_W-1:0]  src,
   input  logic              m_live,
   input  logic [TAG_W-1:0]  m_dst,
   input  logic              w_live,
   input  logic [TAG_W-1:0]  w_dst,
   output logic [1:0]        sel
);

   logic src_ok;

   if (ZERO_TAG_EN != 0) begin : g_zero_gate
      assign src_ok = (src != '0);
   end else begin : g_no_gate
      assign src_ok = 1'b1;
   end

   always_comb begin
      sel = FWD_RF;
      if (need && src_ok) begin
         if (m_live && (m_dst == src)) begin
            sel = FWD_MEM;
         end else if (w_live && (w_dst == src)) begin
            sel = FWD_WB;
         end
      end
   end

endmodule

// File: rtl/hzc_ctrl.sv
module hzc_ctrl
   import hzc_pkg::*;
#(
   parameter int TAG_W       = 5,
   parameter int FP_STAGES   = 4,
   parameter int ZERO_TAG_EN = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              id_valid,
   input  logic [2:0]        id_cls,
   input  logic [TAG_W-1:0]  id_src_a,
   input  logic [TAG_W-1:0]  id_src_b,
   input  logic [TAG_W-1:0]  id_dst,
   output logic              front_hold,
   output logic              issue_bubble,
   output logic              issue_hold,
   output logic              mem_from_fp,
   output logic [1:0]        fwd_a,
   output logic [1:0]        fwd_b,
   output logic [1:0]        fwd_sd
);

   localparam int NSEL = 3;

   if (TAG_W < 1) begin : g_bad_tag
      $error("hzc_ctrl: TAG_W must be at least 1");
   end
   if (FP_STAGES < 2) begin : g_bad_depth
      $error("hzc_ctrl: FP_STAGES must be at least 2");
   end

   logic                              issue_en, mem_clash;
   logic                              x_valid;
   logic [2:0]                        x_cls;
   logic [TAG_W-1:0]                  x_src_a, x_src_b, x_dst;
   logic [FP_STAGES-1:1]              fp_valid;
   logic [FP_STAGES-1:1][TAG_W-1:0]   fp_dst;
   logic                              m_valid, w_valid;
   logic [2:0]                        m_cls, w_cls;
   logic [TAG_W-1:0]                  m_dst, w_dst;
   logic                              m_live, w_live;
   logic [NSEL-1:0]                   sel_need;
   logic [NSEL-1:0][TAG_W-1:0]        sel_src;
   logic [NSEL-1:0][1:0]              sel_out;

   assign issue_en   = id_valid && !front_hold;
   assign issue_hold = mem_clash;

   hzc_track #(.TAG_W(TAG_W), .FP_STAGES(FP_STAGES)) track_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .issue_en   (issue_en),
      .id_cls     (id_cls),
      .id_src_a   (id_src_a),
      .id_src_b   (id_src_b),
      .id_dst     (id_dst),
      .x_valid    (x_valid),
      .x_cls      (x_cls),
      .x_src_a    (x_src_a),
      .x_src_b    (x_src_b),
      .x_dst      (x_dst),
      .fp_valid   (fp_valid),
      .fp_dst     (fp_dst),
      .m_valid    (m_valid),
      .m_cls      (m_cls),
      .m_dst      (m_dst),
      .w_valid    (w_valid),
      .w_cls      (w_cls),
      .w_dst      (w_dst),
      .mem_clash  (mem_clash),
      .mem_from_fp(mem_from_fp)
   );

   hzc_detect #(.TAG_W(TAG_W), .FP_STAGES(FP_STAGES), .ZERO_TAG_EN(ZERO_TAG_EN)) detect_i (
      .id_valid    (id_valid),
      .id_cls      (id_cls),
      .id_src_a    (id_src_a),
      .id_src_b    (id_src_b),
      .id_dst      (id_dst),
      .x_valid     (x_valid),
      .x_cls       (x_cls),
      .x_dst       (x_dst),
      .fp_valid    (fp_valid),
      .fp_dst      (fp_dst),
      .mem_clash   (mem_clash),
      .front_hold  (front_hold),
      .issue_bubble(issue_bubble)
   );

   assign m_live = m_valid && cls_early(m_cls);
   assign w_live = w_valid && cls_writes(w_cls);

   // operand index 0: first source, 1: execute second source, 2: store data
   assign sel_need[0] = x_valid;
   assign sel_need[1] = x_valid && cls_exec_b(x_cls);
   assign sel_need[2] = x_valid && cls_stores(x_cls);
   assign sel_src[0]  = x_src_a;
   assign sel_src[1]  = x_src_b;
   assign sel_src[2]  = x_src_b;

   for (genvar s = 0; s < NSEL; s++) begin : g_sel
      hzc_fwd_sel #(.TAG_W(TAG_W), .ZERO_TAG_EN(ZERO_TAG_EN)) sel_i (
         .need  (sel_need[s]),
         .src   (sel_src[s]),
         .m_live(m_live),
         .m_dst (m_dst),
         .w_live(w_live),
         .w_dst (w_dst),
         .sel   (sel_out[s])
      );
   end

   assign fwd_a  = sel_out[0];
   assign fwd_b  = sel_out[1];
   assign fwd_sd = sel_out[2];

endmodule

// File: rtl/hzc_ctrl_chk.sv
module hzc_ctrl_chk
   import hzc_pkg::*;
#(
   parameter int TAG_W       = 5,
   parameter int ZERO_TAG_EN = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              id_valid,
   input logic [2:0]        id_cls,
   input logic [TAG_W-1:0]  id_src_a,
   input logic [TAG_W-1:0]  id_src_b,
   input logic              front_hold,
   input logic              issue_bubble,
   input logic              issue_hold,
   input logic              mem_from_fp,
   input logic [1:0]        fwd_a,
   input logic [1:0]        fwd_b,
   input logic [1:0]        fwd_sd,
   input logic              x_valid,
   input logic [2:0]        x_cls,
   input logic [TAG_W-1:0]  x_dst
);

   // R3
   load_use_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (id_valid && x_valid && (x_cls == CL_LOAD) && (x_dst != '0) && (id_src_a == x_dst))
      |-> (front_hold && (issue_bubble || issue_hold)));

   // R6
   port_clash_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      issue_hold |-> (front_hold && !issue_bubble && mem_from_fp));

   // R8
   bubble_empty_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      issue_bubble |=> ((fwd_a == FWD_RF) && (fwd_b == FWD_RF) && (fwd_sd == FWD_RF)));

   // R9
   zero_tag_no_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((ZERO_TAG_EN != 0) && id_valid && !front_hold && (id_src_a == '0)) |=> (fwd_a == FWD_RF));

   // R4
   alu_store_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (id_valid && (id_cls == CL_STORE) && !front_hold && x_valid && (x_cls == CL_ALU) &&
       (x_dst != '0) && (id_src_b == x_dst)) |=> (fwd_sd == FWD_MEM));

   // R7
   sel_code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_a != 2'b11) && (fwd_b != 2'b11) && (fwd_sd != 2'b11));

endmodule

bind hzc_ctrl hzc_ctrl_chk #(.TAG_W(TAG_W), .ZERO_TAG_EN(ZERO_TAG_EN)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .id_valid    (id_valid),
   .id_cls      (id_cls),
   .id_src_a    (id_src_a),
   .id_src_b    (id_src_b),
   .front_hold  (front_hold),
   .issue_bubble(issue_bubble),
   .issue_hold  (issue_hold),
   .mem_from_fp (mem_from_fp),
   .fwd_a       (fwd_a),
   .fwd_b       (fwd_b),
   .fwd_sd      (fwd_sd),
   .x_valid     (x_valid),
   .x_cls       (x_cls),
   .x_dst       (x_dst)
);

// File: tb/hzc_ctrl_tb_top.sv
module hzc_ctrl_tb_top;

   localparam logic [2:0] K_ALU = 3'd0, K_LD = 3'd1, K_ST = 3'd2, K_FA = 3'd3, K_FS = 3'd4;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       id_valid;
   logic [2:0] id_cls;
   logic [4:0] id_src_a, id_src_b, id_dst;
   logic       front_hold, issue_bubble, issue_hold, mem_from_fp;
   logic [1:0] fwd_a, fwd_b, fwd_sd;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   hzc_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_cls(id_cls),
      .id_src_a(id_src_a), .id_src_b(id_src_b), .id_dst(id_dst),
      .front_hold(front_hold), .issue_bubble(issue_bubble), .issue_hold(issue_hold),
      .mem_from_fp(mem_from_fp), .fwd_a(fwd_a), .fwd_b(fwd_b), .fwd_sd(fwd_sd)
   );

   // bench-side occupancy record
   logic       sx_v;  logic [2:0] sx_c;  logic [4:0] sx_a, sx_b, sx_d;
   logic       sf_v [1:3]; logic [4:0] sf_d [1:3];
   logic       sm_v;  logic [2:0] sm_c;  logic [4:0] sm_d;
   logic       sw_v;  logic [2:0] sw_c;  logic [4:0] sw_d;

   // expected and observed
   logic e_hold, e_bub, e_ihold, e_mfp;
   logic [1:0] e_fa, e_fb, e_fsd;
   logic o_hold, o_bub, o_ihold, o_mfp;
   logic [1:0] o_fa, o_fb, o_fsd;

   task automatic chk(input logic ok, input string tag, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   task automatic clear_model();
      sx_v = 0; sx_c = K_ALU; sx_a = 0; sx_b = 0; sx_d = 0;
      for (int k = 1; k <= 3; k++) begin sf_v[k] = 0; sf_d[k] = 0; end
      sm_v = 0; sm_c = K_ALU; sm_d = 0;
      sw_v = 0; sw_c = K_ALU; sw_d = 0;
   endtask

   function automatic logic [1:0] pick(input logic [4:0] t);
      if (t == 0) return 2'b00;
      if (sm_v && (sm_c == K_ALU || sm_c == K_FA) && sm_d == t) return 2'b10;
      if (sw_v && (sw_c == K_ALU || sw_c == K_LD || sw_c == K_FA) && sw_d == t) return 2'b01;
      return 2'b00;
   endfunction

   function automatic logic blocks(input logic pv, input logic [4:0] pd, input logic rb, input logic wr,
                                   input logic [4:0] a, input logic [4:0] b, input logic [4:0] d);
      return pv && pd != 0 && (a == pd || (rb && b == pd) || (wr && d == pd));
   endfunction

   task automatic expect_now(input logic v, input logic [2:0] c, input logic [4:0] a, b, d);
      logic rb, wr, lu, fw, hz, cl;
      rb = (c == K_ALU) || (c == K_ST) || (c == K_FA) || (c == K_FS);
      wr = (c == K_ALU) || (c == K_LD) || (c == K_FA);
      lu = sx_v && sx_c == K_LD && sx_d != 0 && (a == sx_d || (rb && b == sx_d));
      fw = blocks(sx_v && sx_c == K_FA, sx_d, rb, wr, a, b, d) ||
           blocks(sf_v[1], sf_d[1], rb, wr, a, b, d) ||
           blocks(sf_v[2], sf_d[2], rb, wr, a, b, d);
      hz = v && (lu || fw);
      cl = sx_v && sx_c != K_FA && sf_v[3];
      e_hold  = hz || cl;
      e_bub   = hz && !cl;
      e_ihold = cl;
      e_mfp   = sf_v[3];
      e_fa    = sx_v ? pick(sx_a) : 2'b00;
      e_fb    = (sx_v && (sx_c == K_ALU || sx_c == K_FA)) ? pick(sx_b) : 2'b00;
      e_fsd   = (sx_v && (sx_c == K_ST || sx_c == K_FS)) ? pick(sx_b) : 2'b00;
   endtask

   task automatic advance(input logic v, input logic [2:0] c, input logic [4:0] a, b, d);
      sw_v = sm_v; sw_c = sm_c; sw_d = sm_d;
      if (sf_v[3]) begin sm_v = 1; sm_c = K_FA; sm_d = sf_d[3]; end
      else if (sx_v && sx_c != K_FA) begin sm_v = 1; sm_c = sx_c; sm_d = sx_d; end
      else sm_v = 0;
      sf_v[3] = sf_v[2]; sf_d[3] = sf_d[2];
      sf_v[2] = sf_v[1]; sf_d[2] = sf_d[1];
      sf_v[1] = sx_v && sx_c == K_FA; sf_d[1] = sx_d;
      if (!e_ihold) begin
         sx_v = v && !e_hold;
         if (v && !e_hold) begin sx_c = c; sx_a = a; sx_b = b; sx_d = d; end
      end
   endtask

   task automatic step(input logic v, input logic [2:0] c, input logic [4:0] a, b, d, output logic acc);
      @(negedge clk);
      id_valid = v; id_cls = c; id_src_a = a; id_src_b = b; id_dst = d;
      #2;
      expect_now(v, c, a, b, d);
      o_hold = front_hold; o_bub = issue_bubble; o_ihold = issue_hold; o_mfp = mem_from_fp;
      o_fa = fwd_a; o_fb = fwd_b; o_fsd = fwd_sd;
      chk(o_hold == e_hold,   "R3/R5/R6", "front_hold", o_hold, e_hold);
      chk(o_bub == e_bub,     "R3/R5", "issue_bubble", o_bub, e_bub);
      chk(o_ihold == e_ihold, "R6", "issue_hold", o_ihold, e_ihold);
      chk(o_mfp == e_mfp,     "R10", "mem_from_fp", o_mfp, e_mfp);
      chk(o_fa == e_fa,       "R7", "fwd_a", o_fa, e_fa);
      chk(o_fb == e_fb,       "R8", "fwd_b", o_fb, e_fb);
      chk(o_fsd == e_fsd,     "R4/R8", "fwd_sd", o_fsd, e_fsd);
      @(posedge clk);
      advance(v, c, a, b, d);
      acc = v && !e_hold;
   endtask

   task automatic idle();
      logic acc;
      step(1'b0, K_ALU, 5'd0, 5'd0, 5'd0, acc);
   endtask

   task automatic drain();
      for (int i = 0; i < 7; i++) idle();
   endtask

   task automatic issue(input logic [2:0] c, input logic [4:0] a, b, d, output int waits);
      logic acc;
      waits = 0;
      acc = 0;
      while (!acc) begin
         step(1'b1, c, a, b, d, acc);
         if (!acc) waits++;
         if (waits > 20) begin
            chk(1'b0, "R3/R5/R6", "issue never accepted", waits, 0);
            acc = 1;
         end
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog expired, run hung");
         summary();
      end
   end

   initial begin
      int w;
      int unsigned seed_val;
      clear_model();
      rst_n = 0; id_valid = 0; id_cls = K_ALU; id_src_a = 0; id_src_b = 0; id_dst = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R2 reset state
      chk(!front_hold && !issue_bubble && !issue_hold && !mem_from_fp, "R2", "hold flags in reset",
          {front_hold, issue_bubble, issue_hold, mem_from_fp}, 0);
      chk(fwd_a == 0 && fwd_b == 0 && fwd_sd == 0, "R2", "selects in reset", {fwd_a, fwd_b, fwd_sd}, 0);
      rst_n = 1;
      idle();
      chk(!o_hold && !o_bub && !o_ihold && !o_mfp && o_fa == 0, "R2", "state after reset", o_hold, 0);

      // R4 ALU result feeding store data
      issue(K_ALU, 5'd2, 5'd3, 5'd1, w);
      issue(K_ST, 5'd4, 5'd1, 5'd0, w);
      chk(w == 0, "R4", "store after ALU waits", w, 0);
      idle();
      chk(o_fsd == 2'b10, "R4", "fwd_sd after ALU", o_fsd, 2);
      drain();

      // R3 load-use
      issue(K_LD, 5'd4, 5'd0, 5'd5, w);
      issue(K_ALU, 5'd5, 5'd2, 5'd6, w);
      chk(w == 1, "R3", "load-use stall cycles", w, 1);
      idle();
      chk(o_fa == 2'b01, "R3", "fwd_a after load", o_fa, 1);
      drain();

      // R5 FP add then dependent store
      issue(K_FA, 5'd2, 5'd3, 5'd6, w);
      issue(K_ST, 5'd4, 5'd6, 5'd0, w);
      chk(w == 3, "R5", "store behind FP add waits", w, 3);
      idle();
      chk(o_fsd == 2'b10, "R5", "fwd_sd from adder", o_fsd, 2);
      drain();

      // R1 FP store reads b; load ignores b
      issue(K_FA, 5'd2, 5'd3, 5'd7, w);
      issue(K_FS, 5'd4, 5'd7, 5'd0, w);
      chk(w == 3, "R1", "FP store data dependency", w, 3);
      drain();
      issue(K_LD, 5'd4, 5'd0, 5'd8, w);
      issue(K_LD, 5'd2, 5'd8, 5'd9, w);
      chk(w == 0, "R1", "load second source ignored", w, 0);
      drain();

      // R6 / R10 memory-port conflict
      issue(K_FA, 5'd1, 5'd2, 5'd10, w);
      issue(K_ALU, 5'd3, 5'd4, 5'd11, w);
      issue(K_ALU, 5'd3, 5'd4, 5'd12, w);
      issue(K_ALU, 5'd3, 5'd4, 5'd13, w);
      idle();
      chk(o_ihold && o_hold && !o_bub, "R6", "structural hold", {o_ihold, o_hold, o_bub}, 6);
      chk(o_mfp, "R10", "adder owns memory port", o_mfp, 1);
      idle();
      chk(!o_ihold, "R6", "hold released", o_ihold, 0);
      drain();

      // R9 tag zero
      issue(K_ALU, 5'd1, 5'd2, 5'd0, w);
      issue(K_ALU, 5'd0, 5'd0, 5'd3, w);
      idle();
      chk(o_fa == 0 && o_fb == 0, "R9", "tag zero not forwarded", {o_fa, o_fb}, 0);
      issue(K_LD, 5'd1, 5'd0, 5'd0, w);
      issue(K_ALU, 5'd0, 5'd2, 5'd4, w);
      chk(w == 0, "R9", "tag zero load no stall", w, 0);
      drain();

      // R7 priority of memory-stage result
      issue(K_ALU, 5'd1, 5'd2, 5'd5, w);
      issue(K_ALU, 5'd1, 5'd2, 5'd5, w);
      issue(K_ALU, 5'd5, 5'd1, 5'd6, w);
      idle();
      chk(o_fa == 2'b10, "R7", "EX/MEM beats MEM/WB", o_fa, 2);
      drain();

      // R8 second operand from writeback only
      issue(K_ALU, 5'd1, 5'd2, 5'd7, w);
      idle();
      issue(K_ALU, 5'd3, 5'd7, 5'd8, w);
      idle();
      chk(o_fb == 2'b01, "R8", "fwd_b from writeback", o_fb, 1);
      drain();
      issue(K_ALU, 5'd1, 5'd2, 5'd9, w);
      issue(K_ST, 5'd1, 5'd9, 5'd0, w);
      idle();
      chk(o_fb == 0 && o_fsd == 2'b10, "R8", "store uses fwd_sd not fwd_b", {o_fb, o_fsd}, 2);
      drain();

      // random phase
      seed_val = $urandom(32'd2024);
      for (int n = 0; n < 600; n++) begin
         logic [2:0] c;
         logic [4:0] a, b, d;
         c = 3'($urandom % 5);
         a = ($urandom % 8 == 0) ? 5'($urandom % 32) : 5'($urandom % 4);
         b = 5'($urandom % 4);
         d = 5'($urandom % 4);
         if ($urandom % 5 == 0) idle();
         else issue(c, a, b, d, w);
      end
      drain();
      summary();
   end

endmodule